// File: doc/BRIEF.md
# Two-Wire Serial Converter Result Reader

This block is a host-side master that pulls conversion results out of a delta-sigma converter over just two wires: a serial clock it drives and a serial data line it reads. Chip select is held low all the time, so each frame starts and stops on its own. While no frame is running, the reader polls a ready line. That line is either the data line or a separate busy pin, chosen by `use_busy`. A low level means a result is waiting. A high level means a conversion is still in progress.

When the ready line goes low, the reader issues exactly 32 clock pulses. Each half of a pulse lasts `half_period` system clocks. It captures one bit per pulse while the clock is high, because the converter changes its output only on falling edges. It then splits the 32-bit word into two header bits, a sign bit and a 29-bit magnitude. The result appears with a one-cycle valid strobe and a header error flag.

After a frame, the converter starts its next conversion and drives the ready line high. The reader waits for that high level, and only then goes back to watching for low. This stops a line that is still low from starting a second read of the same result.

States:
- `S_IDLE`: polls the ready line.
- `S_LO`: serial clock low phase.
- `S_HI`: serial clock high phase, with the sample taken on its last cycle.
- `S_REARM`: waits for the ready line to go high.

Transitions:
- `S_IDLE`→`S_LO` when the ready line is low.
- `S_LO`→`S_HI` at the end of the phase.
- `S_HI`→`S_LO` at the end of the phase if bits remain.
- `S_HI`→`S_REARM` after the 32nd bit.
- `S_REARM`→`S_IDLE` when the ready line is high.

Top module: `adc2w_reader`

## Requirements
- R1: In `S_IDLE`, a frame starts only once the selected ready line is low. With `use_busy`=0 the selected line is `sdo` and `busy` is ignored. With `use_busy`=1 the selected line is `busy` and `sdo` is ignored.
- R2: Each frame has exactly 32 rising edges of `sck`.
- R3: Every `sck` high phase and low phase lasts `half_period` system clocks, with a minimum of 2. `sck` is low whenever no frame is running.
- R4: A bit is taken on the last system cycle of each high phase, and the first bit taken is frame bit 31. `res_sign` is frame bit 29. `res_mag` is frame bits 28 down to 0, with the first-received bit as its MSB.
- R5: `res_valid` is high for exactly the one system cycle that begins with the 32nd falling edge of `sck`. The result fields are valid in that cycle.
- R6: `hdr_err` is the OR of frame bit 31 (the ready bit) and frame bit 30 (the fixed-zero bit).
- R7: After a frame, a new frame does not start until the selected ready line has been seen high and then low again.
- R8: `half_period` is captured when a frame starts. A change during a frame does not affect that frame.
- R9: After reset, `sck`, `res_valid`, `res_sign`, `res_mag` and `hdr_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | DIV_W | System clocks per `sck` phase (minimum 2) |
| use_busy | input | 1 | 1: ready taken from `busy`; 0: ready taken from `sdo` |
| sdo | input | 1 | Serial data from the converter |
| busy | input | 1 | Converter busy pin, high while converting |
| sck | output | 1 | Serial clock to the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_sign | output | 1 | Sign bit of the frame |
| res_mag | output | MAG_W | Magnitude, MSB first as received |
| hdr_err | output | 1 | Header bit 31 or bit 30 read as 1 |

## Verification
The following are checked on every cycle:
- `sck` stays low in the cycle after any idle-state cycle.
- `sck` is low while the strobe is high.
- The strobe never lasts two cycles.
- The bit counter stays within the frame while the clock is toggling.
- A low ready line during re-arm keeps the reader in re-arm.
- The captured divider does not change mid-frame.

Some properties need whole scenarios against a converter model, so only the bench can show them:
- Exactly 32 pulses per frame, and the total high time in each frame.
- That the unselected ready line is ignored.
- That data decodes correctly for all-ones, all-zeros and random words.
- That header errors come from either header bit.
- That a held-low line does not start a second read.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LO    = 2'd1,
        S_HI    = 2'd2,
        S_REARM = 2'd3
    } rd_state_t;

    localparam int HDR_BITS = 3;
endpackage

// File: rtl/adc2w_sync.sv
module adc2w_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2+1-1:0], d} >> 0;
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/adc2w_reader.sv
module adc2w_reader
    import adc2w_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MAG_W       = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_period,
    input  logic             use_busy,
    input  logic             sdo,
    input  logic             busy,
    output logic             sck,
    output logic             res_valid,
    output logic             res_sign,
    output logic [MAG_W-1:0] res_mag,
    output logic             hdr_err
);
    localparam int FRAME_W = MAG_W + HDR_BITS;
    localparam int BIT_W   = $clog2(FRAME_W + 1);

    logic sdo_s, busy_s, ready_n;

    adc2w_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sdo (
        .clk(clk), .rst_n(rst_n), .d(sdo), .q(sdo_s)
    );
    adc2w_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_busy (
        .clk(clk), .rst_n(rst_n), .d(busy), .q(busy_s)
    );

    // low on the selected line means a result is waiting
    assign ready_n = use_busy ? busy_s : sdo_s;

    rd_state_t          state, nxt;
    logic [DIV_W-1:0]   cnt, half_q;
    logic [BIT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg, word;
    logic               phase_end, last_bit, frame_done;

    assign phase_end  = ({1'b0, cnt} + 1'b1) >= {1'b0, half_q};
    assign last_bit   = bit_cnt == BIT_W'(FRAME_W - 1);
    assign word       = {shreg[FRAME_W-2:0], sdo_s};
    assign frame_done = (state == S_HI) && phase_end && last_bit;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (!ready_n)  nxt = S_LO;
            S_LO:    if (phase_end) nxt = S_HI;
            S_HI:    if (phase_end) nxt = last_bit ? S_REARM : S_LO;
            S_REARM: if (ready_n)   nxt = S_IDLE;
            default:                nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // phase timer, bit counter, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            half_q  <= DIV_W'(2);
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            if (state != nxt)
                cnt <= '0;
            else if (state == S_LO || state == S_HI)
                cnt <= cnt + 1'b1;
            if (state == S_IDLE) begin
                half_q  <= half_period;
                bit_cnt <= '0;
            end else if (state == S_HI && phase_end) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= word;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck       <= 1'b0;
            res_valid <= 1'b0;
            res_sign  <= 1'b0;
            res_mag   <= '0;
            hdr_err   <= 1'b0;
        end else begin
            sck       <= (nxt == S_HI);
            res_valid <= frame_done;
            if (frame_done) begin
                res_sign <= word[FRAME_W-3];
                res_mag  <= word[MAG_W-1:0];
                hdr_err  <= word[FRAME_W-1] | word[FRAME_W-2];
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);                                   // R5
    AST_SCK_LOW_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !sck);                                         // R3
    AST_NO_SCK_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> !sck);                                 // R1
    AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LO || state == S_HI) |-> (bit_cnt < BIT_W'(FRAME_W))); // R2
    AST_REARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REARM && !ready_n) |=> (state == S_REARM));      // R7
    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(half_q));                      // R8
endmodule

// File: tb/sim_adc2w_reader.sv
`timescale 1ns/1ps
module sim_adc2w_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  half_period = 8'd3;
    logic        use_busy = 1'b0;
    logic        sdo = 1'b1;
    logic        busy = 1'b1;
    logic        sck, res_valid, res_sign, hdr_err;
    logic [28:0] res_mag;

    always #2.5 clk = ~clk;

    adc2w_reader u0 (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .use_busy(use_busy),
        .sdo(sdo), .busy(busy), .sck(sck), .res_valid(res_valid),
        .res_sign(res_sign), .res_mag(res_mag), .hdr_err(hdr_err)
    );

    int checks = 0;
    int errors = 0;
    int rises = 0;
    int hi_cyc = 0;
    int vcount = 0;
    logic sck_d = 1'b0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (sck && !sck_d) rises++;
        if (sck) hi_cyc++;
        if (res_valid) vcount++;
        sck_d = sck;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic exp_err(input logic [31:0] w);
        return w[31] | w[30];
    endfunction

    // one converter frame; bmode selects busy pin as ready line
    task automatic run_frame(input logic [31:0] w, input bit bmode, input int half,
                             input int conv, input int lag, input bit hold_low,
                             input int half_new);
        use_busy    = bmode;
        half_period = 8'(half);
        sdo  = 1'b1;
        busy = bmode ? 1'b1 : 1'b0;   // unselected line shows "ready" early
        rises = 0;
        repeat (conv) @(posedge clk);
        #1;
        if (bmode) begin
            sdo = w[31];               // sdo low (or bad) while busy still high
            repeat (lag) @(posedge clk);
            #1;
        end
        chk(rises == 0, "R1", "sck pulses before selected line ready", rises, 0);
        rises = 0; hi_cyc = 0; vcount = 0;
        if (bmode) busy = 1'b0; else sdo = w[31];
        for (int i = 30; i >= 0; i--) begin
            @(negedge sck);
            #1 sdo = w[i];
            if (i == 30 && half_new != 0) half_period = 8'(half_new);
        end
        @(negedge sck);
        @(negedge clk);
        chk(res_valid == 1'b1, "R5", "valid after 32nd fall", res_valid, 1);
        chk(res_sign == w[29], "R4", "sign", res_sign, w[29]);
        chk(res_mag == w[28:0], "R4", "magnitude", res_mag, w[28:0]);
        chk(hdr_err == exp_err(w), "R6", "header error", hdr_err, exp_err(w));
        @(negedge clk);
        chk(res_valid == 1'b0, "R5", "valid width", res_valid, 0);
        chk(vcount == 1, "R5", "valid count", vcount, 1);
        chk(rises == 32, "R2", "sck pulses per frame", rises, 32);
        chk(hi_cyc == 32 * half, "R3", "sck high cycles (R8 divider lock)", hi_cyc, 32 * half);
        chk(sck == 1'b0, "R3", "sck idle level", sck, 0);
        if (hold_low) begin
            sdo = 1'b0; busy = 1'b0;
            repeat (40) @(posedge clk);
            @(negedge clk);
            chk(rises == 32, "R7", "no restart while line stays low", rises, 32);
        end
        #1 sdo = 1'b1; busy = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] w;
        bit bm;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(sck == 1'b0, "R9", "sck after reset", sck, 0);
        chk(res_valid == 1'b0, "R9", "valid after reset", res_valid, 0);
        chk(hdr_err == 1'b0, "R9", "hdr_err after reset", hdr_err, 0);
        chk(res_mag == '0 && res_sign == 1'b0, "R9", "result after reset", res_mag, 0);

        // directed corners
        run_frame(32'h3FFF_FFFF, 1'b0, 2, 8, 0, 1'b0, 0);   // min divider, all ones
        run_frame(32'h0000_0000, 1'b0, 4, 12, 0, 1'b0, 0);  // all zeros
        run_frame(32'hA000_0001, 1'b1, 3, 10, 15, 1'b0, 0); // ready-bit error, busy mode
        run_frame(32'h5555_5555, 1'b0, 3, 6, 0, 1'b0, 0);   // fixed-zero bit error
        run_frame(32'h2AAA_AAAA, 1'b0, 3, 6, 0, 1'b1, 0);   // R7 hold low
        run_frame(32'h1234_5678, 1'b1, 3, 6, 5, 1'b1, 0);   // R7 in busy mode
        run_frame(32'h0F0F_0F0F, 1'b0, 3, 6, 0, 1'b0, 6);   // R8 mid-frame change

        // constrained random
        for (int k = 0; k < 16; k++) begin
            bm = $urandom_range(1, 0) == 1;
            w  = $urandom;
            if (!bm || $urandom_range(3, 0) != 0) w[31] = 1'b0;
            if ($urandom_range(7, 0) != 0) w[30] = 1'b0;
            run_frame(w, bm, $urandom_range(6, 2), $urandom_range(40, 5),
                      $urandom_range(20, 0), 1'b0,
                      ($urandom_range(3, 0) == 0) ? $urandom_range(6, 2) : 0);
        end
        finish_run();
    end
endmodule